// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous pipelined burst SRAM whose bus never needs an idle cycle when traffic changes direction. Each enabled clock edge accepts one command: a read, a write or a deselect. A read returns its word two enabled edges later. A write takes its data from the data input two enabled edges after the command. Read data and write data therefore occupy the same slot position, and reads and writes can follow each other in any order on consecutive clocks.

Write commands move through two pipeline stages until their data arrives. A read that reaches the array before an older write to the same word has been committed would see stale contents. Coherency logic covers this case: it takes the pending write data and merges it into the read result lane by lane. A load/advance control lets the model either start at a new external address or step through an aligned block of four words, in linear or interleaved order. Clock enable freezes the whole block. A separate asynchronous output enable gates the output drivers.

Top module: `zt_sram`

## Requirements
- R1: A synchronous reset leaves the output drivers off. After reset, an advance issued before any load behaves as a deselect, so its data slot is not driven.
- R2: A read loaded on an enabled edge with every chip enable active puts the addressed word on `dout` after the second enabled edge that follows, and `dout_en` is then 1 (if `oe_n` is 0).
- R3: A write updates only the lanes whose `byte_sel` bit is 1, where bit i covers data bits [9i+8:9i]. The data is taken from `din` on the second enabled edge after the write command. Unselected lanes keep their contents.
- R4: A loaded command is an access only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Any other combination is a deselect, and `dout_en` stays 0 in its data slot.
- R5: In the data slot of a write, `dout_en` is 0.
- R6: While `oe_n` is 1, `dout_en` is 0 without waiting for a clock edge.
- R7: While `clk_en` is 0, no input is sampled, no state advances and `dout` holds its value. Commands driven during a stall have no effect.
- R8: With `load`=0 after an access, the next word of the burst is accessed in the same direction as the load. The upper address bits stay fixed. In linear order (`burst_xor` sampled as 0 at load) the low two bits are (start + n) mod 4.
- R9: In interleaved order (`burst_xor` sampled as 1 at load), the low two bits of the n-th advance are start XOR n.
- R10: An advance that follows a deselect stays a deselect, however many advances are issued.
- R11: Any mix of reads and writes is accepted on consecutive enabled edges. A read always returns the result of every earlier write, including writes whose data has not yet arrived, merged lane by lane.
- R12: The fourth advance of a burst wraps back to the starting word of its aligned four-word block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; 0 suspends the block |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| load | input | 1 | 1 loads a new address, 0 advances the burst |
| we | input | 1 | 1 for write, 0 for read (sampled on load) |
| byte_sel | input | LANES | Per-lane write select, active high |
| burst_xor | input | 1 | Burst order on load: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data, two enabled edges after the command |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Output driver enable (0 means high impedance) |

## Verification
The properties assume that the chip-enable and load inputs are at valid levels on every enabled edge. They also assume that `oe_n` changes only between edges, so `dout_en` can be compared against it at the next sample. The stimulus drives every input at the falling edge. It writes every word once before any read is issued, so each read has a defined expected value. In the random phase, advances can only follow whatever command came last, and addresses always stay within the parameterised depth. This keeps the bench's burst and coherency model inside the same assumptions as the properties.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  localparam int BURST_W = 2;

  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} burst_order_e;

  // low address bits of a burst step
  function automatic logic [BURST_W-1:0] burst_low(input logic [BURST_W-1:0] start,
                                                   input logic [BURST_W-1:0] step,
                                                   input burst_order_e ord);
    logic [BURST_W-1:0] r;
    if (ord == ORD_XOR) r = start ^ step;
    else r = start + step;
    return r;
  endfunction
endpackage

// File: rtl/zt_sram_seq.sv
module zt_sram_seq
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              load,
  input  logic              ce_ok,
  input  logic              we,
  input  logic              burst_xor,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byte_sel,
  output logic              cmd_valid,
  output logic              cmd_write,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LANES-1:0]  cmd_mask
);
  logic               act_q;
  logic               wr_q;
  burst_order_e       ord_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] step_q;
  logic [BURST_W-1:0] step_nx;

  assign step_nx  = step_q + 1'b1;
  assign cmd_mask = byte_sel;

  always_comb begin
    if (load) begin
      cmd_valid = ce_ok;
      cmd_write = we;
      cmd_addr  = addr;
    end else begin
      cmd_valid = act_q;
      cmd_write = wr_q;
      cmd_addr  = {base_q[ADDR_W-1:BURST_W], burst_low(base_q[BURST_W-1:0], step_nx, ord_q)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      ord_q  <= ORD_LINEAR;
      base_q <= '0;
      step_q <= '0;
    end else if (clk_en) begin
      if (load) begin
        act_q  <= ce_ok;
        wr_q   <= we;
        ord_q  <= burst_xor ? ORD_XOR : ORD_LINEAR;
        base_q <= addr;
        step_q <= '0;
      end else if (act_q) begin
        step_q <= step_nx;
      end
    end
  end
endmodule

// File: rtl/zt_sram_bank.sv
module zt_sram_bank #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              clk_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (clk_en) begin
        if (wr_en && wr_mask[l]) mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
        if (rd_en) q <= mem[rd_addr];
      end
    end

    assign rd_data[l*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/zt_sram_merge.sv
module zt_sram_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              hit,
  input  logic [LANES-1:0]  mask,
  input  logic [DATA_W-1:0] fresh,
  input  logic [DATA_W-1:0] stale,
  output logic [DATA_W-1:0] merged
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[l*LANE_W +: LANE_W] = (hit && mask[l]) ? fresh[l*LANE_W +: LANE_W]
                                                         : stale[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              load,
  input  logic              we,
  input  logic [LANES-1:0]  byte_sel,
  input  logic              burst_xor,
  input  logic [ADDR_W-1:0] addr,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic              ce_ok;
  logic              c_valid, c_write;
  logic [ADDR_W-1:0] c_addr;
  logic [LANES-1:0]  c_mask;

  logic              s1_v, s1_w, s2_v, s2_w;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [LANES-1:0]  s1_m, s2_m;

  logic              fwd_hit_q;
  logic [LANES-1:0]  fwd_mask_q;
  logic [DATA_W-1:0] fwd_data_q;
  logic [DATA_W-1:0] rd_raw, rd_merged;

  logic              out_on_q;
  logic [DATA_W-1:0] dout_q;

  assign ce_ok = ~sel_a_n & sel_b & ~sel_c_n;

  zt_sram_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk(clk), .rst(rst), .clk_en(clk_en), .load(load), .ce_ok(ce_ok), .we(we),
    .burst_xor(burst_xor), .addr(addr), .byte_sel(byte_sel),
    .cmd_valid(c_valid), .cmd_write(c_write), .cmd_addr(c_addr), .cmd_mask(c_mask)
  );

  // two command stages: write address waits here for its data
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0;
      s2_v <= 1'b0;
      s1_w <= 1'b0;
      s2_w <= 1'b0;
    end else if (clk_en) begin
      s1_v <= c_valid;
      s1_w <= c_write;
      s1_a <= c_addr;
      s1_m <= c_mask;
      s2_v <= s1_v;
      s2_w <= s1_w;
      s2_a <= s1_a;
      s2_m <= s1_m;
    end
  end

  zt_sram_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_bank (
    .clk(clk), .clk_en(clk_en),
    .wr_en(s2_v & s2_w), .wr_addr(s2_a), .wr_mask(s2_m), .wr_data(din),
    .rd_en(s1_v & ~s1_w), .rd_addr(s1_a), .rd_data(rd_raw)
  );

  // the only write the array read can miss is the one committing at the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_hit_q <= 1'b0;
    end else if (clk_en) begin
      fwd_hit_q  <= s1_v & ~s1_w & s2_v & s2_w & (s1_a == s2_a);
      fwd_mask_q <= s2_m;
      fwd_data_q <= din;
    end
  end

  zt_sram_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .hit(fwd_hit_q), .mask(fwd_mask_q), .fresh(fwd_data_q), .stale(rd_raw), .merged(rd_merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_on_q <= 1'b0;
      dout_q   <= '0;
    end else if (clk_en) begin
      out_on_q <= s2_v & ~s2_w;
      dout_q   <= (s2_v & ~s2_w) ? rd_merged : '0;
    end
  end

  assign dout    = dout_q;
  assign dout_en = out_on_q & ~oe_n;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              clk_en,
  input logic              load,
  input logic              sel_a_n,
  input logic              sel_b,
  input logic              sel_c_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              s1_valid,
  input logic [ADDR_W-1:0] s1_addr,
  input logic              s2_valid,
  input logic              s2_write
);
  // R6
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst) oe_n |-> !dout_en);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst) !clk_en |=> $stable(dout));

  // R5
  write_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && s2_valid && s2_write) |=> !dout_en);

  // R2
  read_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && s2_valid && !s2_write) |=> (dout_en == !oe_n));

  // R4
  desel_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && load && !(!sel_a_n && sel_b && !sel_c_n)) |=> !s1_valid);

  // R10
  idle_adv_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !load && !s1_valid) |=> !s1_valid);

  // R8 R12
  block_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_en && !load && s1_valid) |=>
      (s1_valid && s1_addr[ADDR_W-1:2] == $past(s1_addr[ADDR_W-1:2])));
endmodule

bind zt_sram zt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .clk_en(clk_en), .load(load),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .oe_n(oe_n),
  .dout(dout), .dout_en(dout_en),
  .s1_valid(s1_v), .s1_addr(s1_a), .s2_valid(s2_v), .s2_write(s2_w)
);

// File: tb/zt_sram_test.sv
module zt_sram_test;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam logic [2:0] ACT = 3'b010;   // {sel_a_n, sel_b, sel_c_n}
  localparam logic [2:0] OFF = 3'b110;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, clk_en, sel_a_n, sel_b, sel_c_n, load, we, burst_xor, oe_n;
  logic [LN-1:0] byte_sel;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic dout_en;

  zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
    .clk(clk), .rst(rst), .clk_en(clk_en), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .load(load), .we(we), .byte_sel(byte_sel),
    .burst_xor(burst_xor), .addr(addr), .oe_n(oe_n), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  int vectors = 0;
  int misses = 0;

  logic [DW-1:0] mem_m [1<<AW];
  int            q_kind [3];   // 0 idle, 1 read, 2 write
  logic [DW-1:0] q_data [3];
  string         q_tag  [3];
  bit            b_act, b_wr, b_ilv, stalled;
  logic [AW-1:0] b_base;
  logic [1:0]    b_step;

  function automatic logic [DW-1:0] rnd_word();
    logic [63:0] w;
    w = {$urandom(), $urandom()};
    return w[DW-1:0];
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  task automatic check_out(input string force_tag);
    string t;
    bit exp_en;
    exp_en = (q_kind[2] == 1) && !oe_n;
    if (force_tag != "") t = force_tag;
    else if (q_kind[2] == 2) t = "R5";
    else if (q_kind[2] == 1 && oe_n) t = "R6";
    else t = q_tag[2];
    vectors++;
    if (dout_en !== exp_en) begin
      misses++;
      $display("FAIL %s: dout_en=%0b expected %0b", t, dout_en, exp_en);
    end else if (exp_en && dout !== q_data[2]) begin
      misses++;
      $display("FAIL %s: dout=%h expected %h", t, dout, q_data[2]);
    end
  endtask

  task automatic cyc(input bit en, input bit ld, input logic [2:0] ce, input bit w,
                     input logic [LN-1:0] bs, input bit il, input logic [AW-1:0] a,
                     input bit oe, input string tag);
    bit cv, cw;
    logic [AW-1:0] ca;
    logic [1:0] lo;
    logic [DW-1:0] wd;
    @(negedge clk);
    check_out(stalled ? "R7" : "");
    stalled = !en;
    clk_en = en; load = ld; {sel_a_n, sel_b, sel_c_n} = ce; we = w;
    byte_sel = bs; burst_xor = il; addr = a; oe_n = oe;
    din = (en && q_kind[1] == 2) ? q_data[1] : rnd_word();
    if (en) begin
      cv = 1'b0; cw = 1'b0; ca = '0;
      if (ld) begin
        b_act = (ce == ACT); b_base = a; b_step = 2'd0; b_wr = w; b_ilv = il;
        cv = b_act; cw = w; ca = a;
      end else if (b_act) begin
        b_step = b_step + 2'd1;
        lo = b_ilv ? (b_base[1:0] ^ b_step) : (b_base[1:0] + b_step);
        ca = {b_base[AW-1:2], lo};
        cv = 1'b1; cw = b_wr;
      end
      for (int i = 2; i > 0; i--) begin
        q_kind[i] = q_kind[i-1]; q_data[i] = q_data[i-1]; q_tag[i] = q_tag[i-1];
      end
      q_tag[0] = tag;
      if (cv && cw) begin
        wd = rnd_word();
        for (int l = 0; l < LN; l++)
          if (bs[l]) mem_m[ca][l*LW +: LW] = wd[l*LW +: LW];
        q_kind[0] = 2; q_data[0] = wd;
      end else if (cv) begin
        q_kind[0] = 1; q_data[0] = mem_m[ca];
      end else begin
        q_kind[0] = 0; q_data[0] = '0;
      end
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cyc(1, 1, ACT, 0, '0, 0, a, 0, tag);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [LN-1:0] bs, input string tag);
    cyc(1, 1, ACT, 1, bs, 0, a, 0, tag);
  endtask
  task automatic idle(input string tag);
    cyc(1, 1, OFF, 0, '0, 0, '0, 0, tag);
  endtask

  initial begin
    #2000000;
    misses++;
    $display("FAIL watchdog (all requirements): run hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 3; i++) begin q_kind[i] = 0; q_data[i] = '0; q_tag[i] = "R1"; end
    b_act = 0; b_wr = 0; b_ilv = 0; b_base = '0; b_step = '0; stalled = 0;
    rst = 1; clk_en = 1; {sel_a_n, sel_b, sel_c_n} = OFF; load = 1; we = 0;
    byte_sel = '0; burst_xor = 0; addr = '0; oe_n = 0; din = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: advances straight after reset stay deselected
    for (int i = 0; i < 3; i++) cyc(1, 0, ACT, 0, '0, 0, '0, 0, "R1");

    // R3: fill every word with full-lane writes
    for (int i = 0; i < (1 << AW); i++) wr(i[AW-1:0], 4'hF, "R3");
    for (int i = 0; i < 4; i++) rd(i[AW-1:0], "R2");

    // R3: partial lane write, read back after the pipeline drains
    wr(6'd5, 4'b0101, "R3");
    idle("R4"); idle("R4");
    rd(6'd5, "R3");

    // R11: read right behind write, one gap, two pending writes
    wr(6'd6, 4'b0010, "R11"); rd(6'd6, "R11");
    wr(6'd7, 4'b1000, "R11"); idle("R4"); rd(6'd7, "R11");
    wr(6'd8, 4'hF, "R11"); wr(6'd8, 4'b0001, "R11"); rd(6'd8, "R11");
    rd(6'd6, "R11");

    // R4: each chip enable inactive in turn
    cyc(1, 1, 3'b110, 0, '0, 0, 6'd9, 0, "R4");
    cyc(1, 1, 3'b000, 0, '0, 0, 6'd9, 0, "R4");
    cyc(1, 1, 3'b011, 0, '0, 0, 6'd9, 0, "R4");
    rd(6'd9, "R2");

    // R8 / R12: linear read burst from 13 wraps to 13
    cyc(1, 1, ACT, 0, '0, 0, 6'd13, 0, "R8");
    for (int i = 0; i < 3; i++) cyc(1, 0, OFF, 1, '0, 1, '0, 0, "R8");
    cyc(1, 0, ACT, 0, '0, 0, '0, 0, "R12");
    // R8: linear write burst then single reads
    cyc(1, 1, ACT, 1, 4'hF, 0, 6'd22, 0, "R8");
    for (int i = 0; i < 3; i++) cyc(1, 0, ACT, 0, 4'b0110, 0, '0, 0, "R8");
    for (int i = 20; i < 24; i++) rd(i[AW-1:0], "R8");

    // R9: interleaved read burst from 14
    cyc(1, 1, ACT, 0, '0, 1, 6'd14, 0, "R9");
    for (int i = 0; i < 4; i++) cyc(1, 0, ACT, 0, '0, 0, '0, 0, "R9");

    // R10: advances after a deselect
    idle("R10");
    for (int i = 0; i < 3; i++) cyc(1, 0, ACT, 1, 4'hF, 0, 6'd3, 0, "R10");
    rd(6'd3, "R10");

    // R7: stall with garbage commands, then data still intact
    rd(6'd30, "R7");
    for (int i = 0; i < 3; i++) cyc(0, 1, ACT, 1, 4'hF, 0, 6'd30, 0, "R7");
    idle("R7"); idle("R7"); idle("R7");
    rd(6'd30, "R7");

    // R6: output enable released during a read slot
    rd(6'd31, "R6"); idle("R6");
    cyc(1, 1, OFF, 0, '0, 0, '0, 1, "R6");
    cyc(1, 1, OFF, 0, '0, 0, '0, 0, "R6");

    // R11: random back-to-back mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] ce;
      ce = ($urandom % 5 == 0) ? 3'($urandom) : ACT;
      cyc($urandom % 10 != 0, $urandom % 4 != 0, ce, 1'($urandom), 4'($urandom),
          1'($urandom), 6'($urandom), $urandom % 10 == 0, "R11");
    end

    for (int i = 0; i < 4; i++) idle("R11");
    @(negedge clk);
    check_out("");
    summary();
    $finish;
  end
endmodule